// File: doc/BRIEF.md
# User-Level CSR Access Unit

This block carries out the six control/status register access instructions of a 32-bit core and keeps the small set of user-level registers those instructions reach. The core hands over an already decoded 12-bit register address, the 3-bit function code, the source register value, and the 5-bit source field. That field is either the source register index or an immediate. A valid strobe marks the request. One clock later the block returns the register's contents as they were before the instruction, together with a flag that marks the access as illegal.

The block keeps one storage for the floating-point status: a 5-bit accrued exception flag field and a 3-bit dynamic rounding mode. This storage is visible at three addresses: the flags alone, the rounding mode alone, and a combined view. It also keeps three 64-bit read-only counters, each seen as a low and a high 32-bit half: a clock-cycle counter, a wall-time counter driven by an external tick, and a retired-instruction counter driven by a retire pulse from the core.

Top module: `ucsr_exec`

## Requirements
- R1: Function code 001 (read-write) replaces the addressed register with the source register value. The response carries the value held before the write.
- R2: Function codes 010 (read-set) and 011 (read-clear) take the source register value as a mask. They OR the mask bits into the addressed register, or clear those bits from it.
- R3: Function codes 101, 110 and 111 perform read-write, read-set and read-clear. Their operand is the 5-bit source field, zero-extended, and the source register value is ignored.
- R4: A read-set or read-clear whose source field is 0 writes nothing, whatever the source register value. A read-write with source field 0 still writes.
- R5: The address map is as follows. Address 0x001 is the 5-bit flags, in bits 4:0. Address 0x002 is the 3-bit rounding mode, in bits 2:0. Address 0x003 is the combined view, with the rounding mode in bits 7:5, the flags in bits 4:0, and zero above bit 7. A write through any of these addresses updates the same shared storage.
- R6: The cycle counter rises by one on every clock after reset. Its low half reads at 0xC00 and its high half at 0xC80.
- R7: The time counter rises by one on each clock with `time_tick` high. Its low half reads at 0xC01 and its high half at 0xC81.
- R8: The retired counter rises by one on each clock with `retire` high. Its low half reads at 0xC02 and its high half at 0xC82.
- R9: A write attempt to a counter address raises `rsp_illegal`, returns data 0 and changes no counter. A read with a zero source field is legal.
- R10: An address outside the nine listed, or function code 000 or 100, raises `rsp_illegal`, returns data 0 and changes no state.
- R11: `rsp_valid` is high exactly one clock after `req_valid`. The returned value is the contents before that request's own update, including a counter increment in the same clock. A request issued in the next clock sees the update.
- R12: After reset, all counters, the flags and the rounding mode are zero, and `rsp_valid`, `rsp_illegal` and `rsp_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 12 | Register address |
| req_func | input | 3 | Access function code |
| req_rs1_val | input | 32 | Source register value |
| req_rs1_idx | input | 5 | Source register index or 5-bit immediate |
| retire | input | 1 | One instruction retired this clock |
| time_tick | input | 1 | Wall-time tick |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_data | output | 32 | Register contents before the update |
| rsp_illegal | output | 1 | Access was rejected |

## Verification
The hardest case to reach is the read-before-update ordering on a counter. A read must return the old count even though the counter steps on the same clock edge. The stimulus raises `time_tick` in the same clock as a time read, then reads again at once, and expects two consecutive values. The aliased storage is reached by writing through one address and reading through the other two, with function-code and immediate masks picked so that every flag and mode bit changes at least once. The cycle counter's absolute value is unknown to the stimulus, so two reads a fixed number of clocks apart are compared by their difference.

// File: rtl/ucsr_pkg.sv
package ucsr_pkg;
  localparam int ADDR_W = 12;
  localparam int FUNC_W = 3;
  localparam int IMM_W  = 5;

  localparam logic [ADDR_W-1:0] A_FLAGS = 12'h001;
  localparam logic [ADDR_W-1:0] A_RMODE = 12'h002;
  localparam logic [ADDR_W-1:0] A_FPCMB = 12'h003;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_RW   = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FLAGS,
    SEL_RMODE,
    SEL_FPCMB,
    SEL_CNT
  } sel_e;

  typedef struct packed {
    logic       legal;
    logic       wr;
    sel_e       sel;
    logic [1:0] cidx;
    logic       hi;
    op_e        op;
  } dec_t;
endpackage

// File: rtl/ucsr_decode.sv
module ucsr_decode
  import ucsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [IMM_W-1:0]  rs1_idx,
  output dec_t              dec,
  output logic [XLEN-1:0]   operand
);
  localparam bit HAS_HI = (XLEN == 32);

  logic zero_src;
  logic wr_try;
  logic is_cnt;
  op_e  op;
  sel_e sel;

  always_comb begin
    op       = op_e'(func[1:0]);
    operand  = func[2] ? {{(XLEN-IMM_W){1'b0}}, rs1_idx} : rs1_val;
    zero_src = (rs1_idx == '0);
    wr_try   = (op == OP_RW) || !zero_src;

    is_cnt = (addr[11:8] == 4'hC) && (addr[6:2] == 5'd0) &&
             (addr[1:0] != 2'b11) && (!addr[7] || HAS_HI);

    if (addr == A_FLAGS)      sel = SEL_FLAGS;
    else if (addr == A_RMODE) sel = SEL_RMODE;
    else if (addr == A_FPCMB) sel = SEL_FPCMB;
    else if (is_cnt)          sel = SEL_CNT;
    else                      sel = SEL_NONE;

    dec.op    = op;
    dec.sel   = sel;
    dec.cidx  = addr[1:0];
    dec.hi    = addr[7];
    dec.legal = (op != OP_NONE) && (sel != SEL_NONE) &&
                !((sel == SEL_CNT) && wr_try);
    dec.wr    = dec.legal && wr_try && (sel != SEL_CNT);
  end
endmodule

// File: rtl/ucsr_counter.sv
module ucsr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ucsr_fpstate.sv
module ucsr_fpstate
  import ucsr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int FLG_W = 5,
  parameter int RM_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  sel_e            sel,
  input  op_e             op,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] rdata,
  output logic [FLG_W-1:0] flags,
  output logic [RM_W-1:0]  rmode
);
  localparam int CMB_W = FLG_W + RM_W;

  logic [FLG_W-1:0] flg_q, flg_d;
  logic [RM_W-1:0]  rm_q,  rm_d;
  logic [XLEN-1:0]  newv;

  // Old view of the shared storage at the selected alias.
  always_comb begin
    case (sel)
      SEL_FLAGS: rdata = {{(XLEN-FLG_W){1'b0}}, flg_q};
      SEL_RMODE: rdata = {{(XLEN-RM_W){1'b0}}, rm_q};
      SEL_FPCMB: rdata = {{(XLEN-CMB_W){1'b0}}, rm_q, flg_q};
      default:   rdata = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_RW:   newv = operand;
      OP_SET:  newv = rdata | operand;
      OP_CLR:  newv = rdata & ~operand;
      default: newv = rdata;
    endcase
    flg_d = flg_q;
    rm_d  = rm_q;
    case (sel)
      SEL_FLAGS: flg_d = newv[FLG_W-1:0];
      SEL_RMODE: rm_d  = newv[RM_W-1:0];
      SEL_FPCMB: begin
        flg_d = newv[FLG_W-1:0];
        rm_d  = newv[CMB_W-1:FLG_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      rm_q  <= '0;
    end else if (wr_en) begin
      flg_q <= flg_d;
      rm_q  <= rm_d;
    end
  end

  assign flags = flg_q;
  assign rmode = rm_q;
endmodule

// File: rtl/ucsr_exec.sv
module ucsr_exec
  import ucsr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64,
  parameter int FLG_W = 5,
  parameter int RM_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [FUNC_W-1:0]     req_func,
  input  logic [XLEN-1:0]       req_rs1_val,
  input  logic [IMM_W-1:0]      req_rs1_idx,
  input  logic                  retire,
  input  logic                  time_tick,
  output logic                  rsp_valid,
  output logic [XLEN-1:0]       rsp_data,
  output logic                  rsp_illegal
);
  localparam int NUM_CNT = 3;

  dec_t             dec;
  logic [XLEN-1:0]  operand;
  logic [XLEN-1:0]  fp_rdata;
  logic [FLG_W-1:0] fp_flags;
  logic [RM_W-1:0]  fp_rmode;
  logic [CNT_W-1:0] cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_pick;
  logic [XLEN-1:0]  rd_val;

  logic            vld_q, vld_d;
  logic            ill_q, ill_d;
  logic [XLEN-1:0] dat_q, dat_d;

  ucsr_decode #(.XLEN(XLEN)) dec_i (
    .addr    (req_addr),
    .func    (req_func),
    .rs1_val (req_rs1_val),
    .rs1_idx (req_rs1_idx),
    .dec     (dec),
    .operand (operand)
  );

  ucsr_fpstate #(.XLEN(XLEN), .FLG_W(FLG_W), .RM_W(RM_W)) fp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_valid && dec.wr),
    .sel     (dec.sel),
    .op      (dec.op),
    .operand (operand),
    .rdata   (fp_rdata),
    .flags   (fp_flags),
    .rmode   (fp_rmode)
  );

  // Index 0 cycles, 1 wall time, 2 retired instructions.
  assign cnt_inc = {retire, time_tick, 1'b1};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ucsr_counter #(.W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_val[g])
    );
  end

  always_comb begin
    case (dec.cidx)
      2'd0:    cnt_pick = cnt_val[0];
      2'd1:    cnt_pick = cnt_val[1];
      default: cnt_pick = cnt_val[2];
    endcase
    if (dec.sel == SEL_CNT)
      rd_val = dec.hi ? cnt_pick[CNT_W-1 -: XLEN] : cnt_pick[XLEN-1:0];
    else
      rd_val = fp_rdata;
  end

  always_comb begin
    vld_d = req_valid;
    ill_d = !dec.legal;
    dat_d = dec.legal ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_q <= 1'b0;
      dat_q <= '0;
    end else if (req_valid) begin
      ill_q <= ill_d;
      dat_q <= dat_d;
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_illegal = ill_q;
  assign rsp_data    = dat_q;
endmodule

// File: rtl/ucsr_exec_chk.sv
module ucsr_exec_chk #(
  parameter int XLEN  = 32,
  parameter int CNT_W = 64,
  parameter int FLG_W = 5,
  parameter int RM_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [11:0]      req_addr,
  input logic [2:0]       req_func,
  input logic [4:0]       req_rs1_idx,
  input logic             retire,
  input logic             time_tick,
  input logic             rsp_valid,
  input logic [XLEN-1:0]  rsp_data,
  input logic             rsp_illegal,
  input logic [FLG_W-1:0] fp_flags,
  input logic [RM_W-1:0]  fp_rmode,
  input logic [CNT_W-1:0] cnt_cyc,
  input logic [CNT_W-1:0] cnt_tim,
  input logic [CNT_W-1:0] cnt_ret
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R9
  counter_write_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[11:8] == 4'hC &&
     (req_func[1:0] == 2'b01 || req_rs1_idx != 5'd0))
    |=> (rsp_illegal && rsp_data == '0));

  // R10
  bad_func_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_func[1:0] == 2'b00)
    |=> (rsp_illegal && $stable(fp_flags) && $stable(fp_rmode)));

  // R4
  zero_mask_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_func[1] && req_rs1_idx == 5'd0)
    |=> ($stable(fp_flags) && $stable(fp_rmode)));

  // R6
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cnt_cyc == $past(cnt_cyc) + 1'b1));

  // R7
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !time_tick |=> $stable(cnt_tim));

  // R8
  retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (cnt_ret == $past(cnt_ret) + 1'b1));

  // R8
  retire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(cnt_ret));
endmodule

bind ucsr_exec ucsr_exec_chk #(
  .XLEN(XLEN), .CNT_W(CNT_W), .FLG_W(FLG_W), .RM_W(RM_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_func    (req_func),
  .req_rs1_idx (req_rs1_idx),
  .retire      (retire),
  .time_tick   (time_tick),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .rsp_illegal (rsp_illegal),
  .fp_flags    (fp_flags),
  .fp_rmode    (fp_rmode),
  .cnt_cyc     (cnt_val[0]),
  .cnt_tim     (cnt_val[1]),
  .cnt_ret     (cnt_val[2])
);

// File: tb/ucsr_exec_tb_top.sv
module ucsr_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_func = '0;
  logic [31:0] req_rs1_val = '0;
  logic [4:0]  req_rs1_idx = '0;
  logic        retire = 1'b0;
  logic        time_tick = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_illegal;

  always #2.5 clk = ~clk;

  ucsr_exec dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_func(req_func), .req_rs1_val(req_rs1_val), .req_rs1_idx(req_rs1_idx),
    .retire(retire), .time_tick(time_tick), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  typedef struct {
    bit          chk;
    logic [31:0] data;
    bit          ill;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] cap_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  // Bench model of the floating-point status storage.
  logic [4:0] m_flg = '0;
  logic [2:0] m_rm  = '0;

  function automatic logic [31:0] fp_view(input logic [11:0] a);
    case (a)
      12'h001: return {27'd0, m_flg};
      12'h002: return {29'd0, m_rm};
      default: return {24'd0, m_rm, m_flg};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] a, input logic [2:0] f, input logic [31:0] v,
                       input logic [4:0] idx, input bit chk, input logic [31:0] ed,
                       input bit ei, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = a;
    req_func    = f;
    req_rs1_val = v;
    req_rs1_idx = idx;
    e.chk = chk; e.data = ed; e.ill = ei; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_fp(input logic [11:0] a, input logic [2:0] f, input logic [31:0] v,
                       input logic [4:0] idx, input string tag);
    logic [31:0] old, opd, nv;
    old = fp_view(a);
    opd = f[2] ? {27'd0, idx} : v;
    case (f[1:0])
      2'b01:   nv = opd;
      2'b10:   nv = old | opd;
      default: nv = old & ~opd;
    endcase
    if (f[1:0] == 2'b01 || idx != 5'd0) begin
      case (a)
        12'h001: m_flg = nv[4:0];
        12'h002: m_rm  = nv[2:0];
        default: begin m_flg = nv[4:0]; m_rm = nv[7:5]; end
      endcase
    end
    issue(a, f, v, idx, 1'b1, old, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      time_tick = 1'b0;
      retire    = 1'b0;
    end
  endtask

  task automatic pulses(input bit tk, input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (tk) time_tick = 1'b1; else retire = 1'b1;
      @(negedge clk);
      time_tick = 1'b0;
      retire    = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard as responses appear.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected response actual %08h expected none", rsp_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.chk) begin
          check({e.tag, " data"}, rsp_data, e.data);
          check({e.tag, " illegal"}, {31'd0, rsp_illegal}, {31'd0, e.ill});
        end else begin
          cap_q.push_back(rsp_data);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, c1;
    repeat (3) @(negedge clk);
    // R12 reset state at the ports
    check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R12 rsp_illegal", {31'd0, rsp_illegal}, 32'd0);
    check("R12 rsp_data", rsp_data, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R12 storage and counters zero after reset
    issue(12'h003, 3'b010, 32'hFFFF_FFFF, 5'd0, 1'b1, 32'd0, 1'b0, "R12 fp zero");
    issue(12'hC01, 3'b010, 32'd0, 5'd0, 1'b1, 32'd0, 1'b0, "R12 time zero");
    issue(12'hC02, 3'b010, 32'd0, 5'd0, 1'b1, 32'd0, 1'b0, "R12 retired zero");

    // R1 read-write from register; R5 aliasing
    do_fp(12'h003, 3'b001, 32'hFFFF_FFAB, 5'd5, "R1 rw combined");
    do_fp(12'h001, 3'b010, 32'd0, 5'd0, "R5 flags alias");
    do_fp(12'h002, 3'b010, 32'd0, 5'd0, "R5 rmode alias");
    // R2 set and clear with register mask
    do_fp(12'h001, 3'b010, 32'h0000_0014, 5'd3, "R2 set flags");
    do_fp(12'h003, 3'b011, 32'h0000_00E1, 5'd7, "R2 clear combined");
    // R3 immediate forms, register value ignored
    do_fp(12'h002, 3'b101, 32'hDEAD_BEEF, 5'd6, "R3 rwi rmode");
    do_fp(12'h001, 3'b110, 32'hDEAD_BEEF, 5'd1, "R3 setI flags");
    do_fp(12'h003, 3'b111, 32'hFFFF_FFFF, 5'd28, "R3 clrI combined");
    // R4 zero source: set/clear no write, rw writes
    do_fp(12'h003, 3'b010, 32'h0000_00FF, 5'd0, "R4 set x0");
    do_fp(12'h003, 3'b111, 32'h0000_00FF, 5'd0, "R4 clrI 0");
    do_fp(12'h003, 3'b010, 32'd0, 5'd0, "R4 after no-write");
    do_fp(12'h001, 3'b001, 32'd0, 5'd0, "R4 rw x0 writes");
    do_fp(12'h003, 3'b010, 32'd0, 5'd0, "R4 after rw x0");
    // R5 upper bits of combined view stay zero
    do_fp(12'h002, 3'b001, 32'hFFFF_FFFF, 5'd9, "R5 rmode all ones");
    do_fp(12'h003, 3'b010, 32'd0, 5'd0, "R5 combined upper zero");
    // R11 back-to-back write then read
    do_fp(12'h001, 3'b101, 32'd0, 5'd9, "R11 write");
    do_fp(12'h001, 3'b010, 32'd0, 5'd0, "R11 next sees write");
    idle(2);

    // R7 time counter
    pulses(1'b1, 5);
    issue(12'hC01, 3'b010, 32'd0, 5'd0, 1'b1, 32'd5, 1'b0, "R7 time low");
    issue(12'hC81, 3'b110, 32'd0, 5'd0, 1'b1, 32'd0, 1'b0, "R7 time high");
    idle(1);
    // R8 retired counter
    pulses(1'b0, 7);
    issue(12'hC02, 3'b010, 32'd0, 5'd0, 1'b1, 32'd7, 1'b0, "R8 retired low");
    issue(12'hC82, 3'b010, 32'd0, 5'd0, 1'b1, 32'd0, 1'b0, "R8 retired high");
    // R11 read in the same clock as the tick sees the old value
    issue(12'hC01, 3'b010, 32'd0, 5'd0, 1'b1, 32'd5, 1'b0, "R11 old on tick");
    time_tick = 1'b1;
    issue(12'hC01, 3'b010, 32'd0, 5'd0, 1'b1, 32'd6, 1'b0, "R11 new after tick");
    time_tick = 1'b0;

    // R6 cycle counter: two reads three clocks apart
    issue(12'hC00, 3'b010, 32'd0, 5'd0, 1'b0, 32'd0, 1'b0, "R6 cap");
    idle(2);
    issue(12'hC00, 3'b010, 32'd0, 5'd0, 1'b0, 32'd0, 1'b0, "R6 cap");
    issue(12'hC80, 3'b010, 32'd0, 5'd0, 1'b1, 32'd0, 1'b0, "R6 cycle high");

    // R9 writes to counters rejected, state untouched
    issue(12'hC00, 3'b001, 32'h1234_5678, 5'd4, 1'b1, 32'd0, 1'b1, "R9 rw counter");
    issue(12'hC01, 3'b010, 32'h0000_0001, 5'd2, 1'b1, 32'd0, 1'b1, "R9 set counter");
    issue(12'hC01, 3'b010, 32'd0, 5'd0, 1'b1, 32'd6, 1'b0, "R9 time unchanged");
    issue(12'hC02, 3'b110, 32'd0, 5'd0, 1'b1, 32'd7, 1'b0, "R9 setI 0 legal");

    // R10 unimplemented address and bad function codes
    issue(12'h004, 3'b010, 32'd0, 5'd0, 1'b1, 32'd0, 1'b1, "R10 addr 004");
    issue(12'h7C0, 3'b001, 32'hFFFF_FFFF, 5'd1, 1'b1, 32'd0, 1'b1, "R10 addr 7C0");
    issue(12'hC03, 3'b010, 32'd0, 5'd0, 1'b1, 32'd0, 1'b1, "R10 addr C03");
    issue(12'h003, 3'b000, 32'hFFFF_FFFF, 5'd31, 1'b1, 32'd0, 1'b1, "R10 func 000");
    issue(12'h003, 3'b100, 32'hFFFF_FFFF, 5'd31, 1'b1, 32'd0, 1'b1, "R10 func 100");
    do_fp(12'h003, 3'b010, 32'd0, 5'd0, "R10 fp unchanged");
    idle(4);

    if (cap_q.size() == 2) begin
      c0 = cap_q.pop_front();
      c1 = cap_q.pop_front();
      check("R6 cycle delta", c1 - c0, 32'd3);
      check("R6 cycle nonzero", {31'd0, (c0 != 32'd0)}, 32'd1);
    end else begin
      check("R6 capture count", cap_q.size(), 32'd2);
    end
    check("R11 scoreboard drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule